// File: doc/BRIEF.md
# Six-Channel Interval Timer Unit

A register-mapped timer block with six independent up-counters. Each channel has its own run control, mode, tick-source select, optional halving of the tick rate, a count register and a compare register. A channel advances only on a pulse of its chosen tick enable. Both tick enables are inputs, so the block contains no clock generation. The bus is a plain write strobe and read strobe with a byte address. Reads are combinational.

Each channel runs in one of three modes. One-shot mode stops the channel after a single compare hit. Repeat mode reloads the count to zero on every hit, which gives a periodic event. Free-run mode counts endlessly and wraps. A compare hit sets a sticky pending bit in a shared interrupt block. Software enables each channel's pending bit onto a single interrupt line and clears pending bits by writing ones.

Top module: `gp_timer_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Channel n (1..6) occupies byte addresses 0x10·n + {0x0 control, 0x4 clock select, 0x8 count, 0xC compare}. In control, bit 0 is run-enable and bits [5:4] are the mode. Bit 1 is a clear command that always reads 0. In clock select, bit 4 is the source (0 = fast tick, 1 = slow tick) and bit 0 is the halving code (1 = divide by two).
- R3: A running channel's count rises by one on each pulse of its selected tick. Pulses on the other tick input, and any pulse while run-enable is 0, leave it unchanged.
- R4: With the halving code set, the count rises on every second pulse of the selected tick. The first pulse after a clear does not advance the count.
- R5: In repeat mode (1), a tick that finds count equal to compare sets the channel's pending bit (bit n−1) and reloads the count to 0. The period is compare+1 ticks.
- R6: In one-shot mode (0), the hit sets the pending bit and drops run-enable. The count stays at the compare value.
- R7: In free-run mode (3), and in the reserved value 2 that behaves the same way, the count wraps from 0xFFFFFFFF to 0 and never sets a pending bit.
- R8: Writing control with bit 1 set zeroes the count and restarts the halving phase. The enable and mode bits written in the same access take effect together with the clear.
- R9: Writing address 0x08 clears each pending bit written as 1. Bits written as 0 have no effect. A hit in the same cycle as its acknowledge leaves the bit set.
- R10: Address 0x00 holds the per-channel interrupt enables (bit n−1). Address 0x04 reads the raw pending bits regardless of the enables. `irq` is high exactly while some pending bit and its enable are both 1.
- R11: The count and compare registers are writable and read back the written value. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| fast_tick | input | 1 | Fast tick enable pulse |
| slow_tick | input | 1 | Slow tick enable pulse |
| irq | output | 1 | Combined interrupt, level |

## Verification
The embedded assertions check on every cycle the following behaviour:
- the count holds when there is no tick, and otherwise moves by exactly one;
- repeat mode reloads to zero on a hit;
- one-shot mode drops run-enable after its hit;
- pending bits are sticky until acknowledged, are set by a hit, and are cleared by a write of one.

Only the bench's scenarios can show the parts that depend on software sequences:
- the address map and field positions;
- the tick-source choice and the divide-by-two phase;
- the free-run wrap;
- the interrupt line against the enable mask.

Each of these is checked against a behavioural model that runs in step with the design.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   typedef enum logic [1:0] {
      MODE_ONCE   = 2'd0,
      MODE_REPEAT = 2'd1,
      MODE_RSVD   = 2'd2,
      MODE_FREE   = 2'd3
   } gpt_mode_e;

   // word index inside a channel's 16-byte window (addr[3:2])
   localparam logic [1:0] W_CTRL   = 2'd0;
   localparam logic [1:0] W_CLKSEL = 2'd1;
   localparam logic [1:0] W_COUNT  = 2'd2;
   localparam logic [1:0] W_CMP    = 2'd3;

   // word index of the shared block (channel slot 0)
   localparam logic [1:0] W_IEN    = 2'd0;
   localparam logic [1:0] W_PEND   = 2'd1;
   localparam logic [1:0] W_ACK    = 2'd2;

   localparam int BIT_RUN  = 0;
   localparam int BIT_CLR  = 1;
   localparam int MODE_LSB = 4;
   localparam int BIT_SRC  = 4;
   localparam int BIT_DIV  = 0;
endpackage

// File: rtl/gpt_channel.sv
module gpt_channel
   import gpt_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 32,
   parameter bit HAS_DIV2 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_tick,
   input  logic              slow_tick,
   input  logic              wr_ctrl,
   input  logic              wr_clksel,
   input  logic              wr_count,
   input  logic              wr_cmp,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] clksel_rd,
   output logic [DATA_W-1:0] count_rd,
   output logic [DATA_W-1:0] cmp_rd,
   output logic              match_o
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("gpt_channel: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < 6) begin : g_bad_data_w
      $error("gpt_channel: DATA_W too narrow for the control fields");
   end

   logic             run_q;
   gpt_mode_e        mode_q;
   logic             src_q;
   logic             div_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic             phase_q;
   logic             tick_sel;
   logic             advance;
   logic             cmp_mode;
   logic             hit;
   logic             clr_cmd;

   assign tick_sel = src_q ? slow_tick : fast_tick;
   assign clr_cmd  = wr_ctrl & wdata[BIT_CLR];
   assign cmp_mode = (mode_q == MODE_ONCE) || (mode_q == MODE_REPEAT);

   if (HAS_DIV2) begin : g_div2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          phase_q <= 1'b0;
         else if (clr_cmd)                    phase_q <= 1'b0;
         else if (run_q && tick_sel && div_q) phase_q <= ~phase_q;
      end
      assign advance = run_q & tick_sel & (~div_q | phase_q);
   end else begin : g_div1
      assign phase_q = 1'b0;
      assign advance = run_q & tick_sel;
   end

   assign hit     = advance & cmp_mode & (cnt_q == cmp_q);
   assign match_o = hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= MODE_ONCE;
      end else if (wr_ctrl) begin
         run_q  <= wdata[BIT_RUN];
         mode_q <= gpt_mode_e'(wdata[MODE_LSB +: 2]);
      end else if (hit && mode_q == MODE_ONCE) begin
         run_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         div_q <= 1'b0;
      end else if (wr_clksel) begin
         src_q <= wdata[BIT_SRC];
         div_q <= HAS_DIV2 ? wdata[BIT_DIV] : 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (wr_count)                 cnt_q <= wdata[CNT_W-1:0];
      else if (clr_cmd)                  cnt_q <= '0;
      else if (hit) begin
         if (mode_q == MODE_REPEAT)      cnt_q <= '0;
      end else if (advance)              cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
   end

   always_comb begin
      ctrl_rd                    = '0;
      ctrl_rd[BIT_RUN]           = run_q;
      ctrl_rd[MODE_LSB +: 2]     = mode_q;
      clksel_rd                  = '0;
      clksel_rd[BIT_SRC]         = src_q;
      clksel_rd[BIT_DIV]         = div_q;
      count_rd                   = DATA_W'(cnt_q);
      cmp_rd                     = DATA_W'(cmp_q);
   end

   // R3: no tick and no write leaves the count alone
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !wr_count && !clr_cmd) |=> $stable(cnt_q));
   // R3: a plain tick moves the count by exactly one
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !hit && !wr_count && !clr_cmd) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode_q == MODE_REPEAT && !wr_count && !clr_cmd) |=> (cnt_q == '0));
   p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode_q == MODE_ONCE && !wr_ctrl) |=> !run_q);
endmodule

// File: rtl/gpt_irq_ctrl.sv
module gpt_irq_ctrl #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ien,
   input  logic              wr_ack,
   input  logic [NUM_CH-1:0] wbits,
   input  logic [NUM_CH-1:0] match_i,
   output logic [NUM_CH-1:0] ien_o,
   output logic [NUM_CH-1:0] pend_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] ien_q;
   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] ack_mask;

   assign ack_mask = wr_ack ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (wr_ien) ien_q <= wbits;
   end

   // a hit in the acknowledge cycle survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack_mask) | match_i;
   end

   assign ien_o  = ien_q;
   assign pend_o = pend_q;
   assign irq_o  = |(pend_q & ien_q);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         match_i[i] |=> pend_q[i]);
      p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ack && wbits[i] && !match_i[i]) |=> !pend_q[i]);
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[i] && !(wr_ack && wbits[i])) |=> pend_q[i]);
   end
endmodule

// File: rtl/gp_timer_unit.sv
module gp_timer_unit
   import gpt_pkg::*;
#(
   parameter int NUM_CH   = 6,
   parameter int CNT_W    = 32,
   parameter int ADDR_W   = 8,
   parameter bit HAS_DIV2 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              fast_tick,
   input  logic              slow_tick,
   output logic              irq
);
   localparam int DATA_W    = 32;
   localparam int SLOT_W    = ADDR_W - 4;

   if (NUM_CH < 1 || NUM_CH >= (1 << SLOT_W)) begin : g_bad_map
      $error("gp_timer_unit: ADDR_W too small for NUM_CH channel windows");
   end
   if (NUM_CH > DATA_W) begin : g_bad_ch
      $error("gp_timer_unit: NUM_CH exceeds data width");
   end

   logic [SLOT_W-1:0] slot;
   logic [1:0]        word;
   logic [NUM_CH-1:0] match;
   logic [NUM_CH-1:0] ien;
   logic [NUM_CH-1:0] pend;
   logic [DATA_W-1:0] ctrl_rd   [NUM_CH];
   logic [DATA_W-1:0] clksel_rd [NUM_CH];
   logic [DATA_W-1:0] count_rd  [NUM_CH];
   logic [DATA_W-1:0] cmp_rd    [NUM_CH];
   logic              shared_wr;

   assign slot      = addr[ADDR_W-1:4];
   assign word      = addr[3:2];
   assign shared_wr = wr_en && (slot == '0);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel;
      assign sel = wr_en && (slot == SLOT_W'(g + 1));
      gpt_channel #(
         .CNT_W    (CNT_W),
         .DATA_W   (DATA_W),
         .HAS_DIV2 (HAS_DIV2)
      ) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .fast_tick (fast_tick),
         .slow_tick (slow_tick),
         .wr_ctrl   (sel && word == W_CTRL),
         .wr_clksel (sel && word == W_CLKSEL),
         .wr_count  (sel && word == W_COUNT),
         .wr_cmp    (sel && word == W_CMP),
         .wdata     (wdata),
         .ctrl_rd   (ctrl_rd[g]),
         .clksel_rd (clksel_rd[g]),
         .count_rd  (count_rd[g]),
         .cmp_rd    (cmp_rd[g]),
         .match_o   (match[g])
      );
   end

   gpt_irq_ctrl #(.NUM_CH(NUM_CH)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ien  (shared_wr && word == W_IEN),
      .wr_ack  (shared_wr && word == W_ACK),
      .wbits   (wdata[NUM_CH-1:0]),
      .match_i (match),
      .ien_o   (ien),
      .pend_o  (pend),
      .irq_o   (irq)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (slot == '0) begin
            case (word)
               W_IEN:   rdata = DATA_W'(ien);
               W_PEND:  rdata = DATA_W'(pend);
               default: rdata = '0;
            endcase
         end else begin
            for (int c = 0; c < NUM_CH; c++) begin
               if (slot == SLOT_W'(c + 1)) begin
                  case (word)
                     W_CTRL:   rdata = ctrl_rd[c];
                     W_CLKSEL: rdata = clksel_rd[c];
                     W_COUNT:  rdata = count_rd[c];
                     default:  rdata = cmp_rd[c];
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: tb/test_gp_timer_unit.sv
module test_gp_timer_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fast_tick = 1'b0;
   logic        slow_tick = 1'b0;
   logic        irq;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   gp_timer_unit i_gp_timer_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .fast_tick(fast_tick),
      .slow_tick(slow_tick), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   bit [31:0] m_cnt [8];
   bit [31:0] m_cmp [8];
   bit [1:0]  m_mode[8];
   bit        m_run [8];
   bit        m_src [8];
   bit        m_div [8];
   bit        m_ph  [8];
   bit [5:0]  m_ien;
   bit [5:0]  m_pend;

   always @(posedge clk) begin
      bit [5:0] hits;
      hits = '0;
      if (!rst_n) begin
         for (int c = 0; c < 8; c++) begin
            m_cnt[c] = 0; m_cmp[c] = 0; m_mode[c] = 0; m_run[c] = 0;
            m_src[c] = 0; m_div[c] = 0; m_ph[c] = 0;
         end
         m_ien = 0; m_pend = 0;
      end else begin
         for (int c = 1; c <= 6; c++) begin
            bit pulse, go;
            pulse = m_src[c] ? slow_tick : fast_tick;
            go = 0;
            if (m_run[c] && pulse) begin
               if (!m_div[c]) go = 1;
               else begin
                  go = m_ph[c];
                  m_ph[c] = !m_ph[c];
               end
            end
            if (go) begin
               if (m_mode[c] <= 1 && m_cnt[c] == m_cmp[c]) begin
                  hits[c-1] = 1;
                  if (m_mode[c] == 1) m_cnt[c] = 0;
                  else m_run[c] = 0;
               end else m_cnt[c] = m_cnt[c] + 1;
            end
            if (wr_en && addr[7:4] == 4'(c)) begin
               case (addr[3:2])
                  2'd0: begin
                     m_run[c] = wdata[0]; m_mode[c] = wdata[5:4];
                     if (wdata[1]) begin m_cnt[c] = 0; m_ph[c] = 0; end
                  end
                  2'd1: begin m_src[c] = wdata[4]; m_div[c] = wdata[0]; end
                  2'd2: m_cnt[c] = wdata;
                  default: m_cmp[c] = wdata;
               endcase
            end
         end
         if (wr_en && addr[7:4] == 0 && addr[3:2] == 2'd2) m_pend = m_pend & ~wdata[5:0];
         m_pend = m_pend | hits;
         if (wr_en && addr[7:4] == 0 && addr[3:2] == 2'd0) m_ien = wdata[5:0];
      end
   end

   function automatic bit [31:0] m_read(input bit [7:0] a);
      int c;
      c = int'(a[7:4]);
      if (c == 0) begin
         if (a[3:2] == 0) return 32'(m_ien);
         if (a[3:2] == 1) return 32'(m_pend);
         return 0;
      end
      if (c > 6) return 0;
      case (a[3:2])
         2'd0: return (32'(m_mode[c]) << 4) | 32'(m_run[c]);
         2'd1: return (32'(m_src[c]) << 4) | 32'(m_div[c]);
         2'd2: return m_cnt[c];
         default: return m_cmp[c];
      endcase
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R10: interrupt line compared every cycle
   always @(negedge clk) begin
      if (rst_n) check("R10 irq", 32'(irq), 32'(|(m_pend & m_ien)));
   end

   task automatic wr(input bit [7:0] a, input bit [31:0] d, input bit ft = 0);
      @(negedge clk);
      rd_en = 0; wr_en = 1; addr = a; wdata = d; fast_tick = ft; slow_tick = 0;
      @(negedge clk);
      wr_en = 0; fast_tick = 0;
   endtask

   task automatic rd(input string req, input bit [7:0] a);
      @(negedge clk);
      wr_en = 0; fast_tick = 0; slow_tick = 0; rd_en = 1; addr = a;
      #1 check(req, rdata, m_read(a));
      rd_en = 0;
   endtask

   task automatic ticks(input int nf, input int ns);
      for (int i = 0; i < nf; i++) begin
         @(negedge clk); fast_tick = 1; slow_tick = 0;
      end
      for (int i = 0; i < ns; i++) begin
         @(negedge clk); fast_tick = 0; slow_tick = 1;
      end
      @(negedge clk); fast_tick = 0; slow_tick = 0;
   endtask

   initial begin
      #(4 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      rd("R1 ien", 8'h00);
      rd("R1 pend", 8'h04);
      rd("R1 ctrl", 8'h10);
      check("R1 count", rdata, 32'h0);
      rd("R1 count ch6", 8'h68);

      // R2 field placement, clear bit reads 0
      wr(8'h20, 32'h33);
      rd("R2 ctrl", 8'h20);
      check("R2 ctrl literal", rdata, 32'h31);
      wr(8'h24, 32'h11);
      rd("R2 clksel", 8'h24);
      check("R2 clksel literal", rdata, 32'h11);
      wr(8'h20, 32'h0);

      // R11 count and compare registers
      wr(8'h3C, 32'h1234);
      wr(8'h38, 32'h55);
      rd("R11 cmp", 8'h3C);
      rd("R11 count", 8'h38);
      check("R11 count literal", rdata, 32'h55);

      // R3 source selection and enable
      wr(8'h10, 32'h33);
      ticks(5, 3);
      rd("R3 fast count", 8'h18);
      check("R3 fast literal", rdata, 32'd5);
      wr(8'h44, 32'h10);
      wr(8'h40, 32'h33);
      ticks(2, 4);
      rd("R3 slow count", 8'h48);
      check("R3 slow literal", rdata, 32'd4);
      wr(8'h40, 32'h32);
      ticks(0, 3);
      rd("R3 disabled hold", 8'h48);

      // R4 divide by two
      wr(8'h54, 32'h01);
      wr(8'h50, 32'h33);
      ticks(7, 0);
      rd("R4 div2 count", 8'h58);
      check("R4 div2 literal", rdata, 32'd3);

      // R8 clear restarts phase
      wr(8'h50, 32'h33);
      ticks(1, 0);
      wr(8'h50, 32'h33);
      ticks(1, 0);
      rd("R8 after clear", 8'h58);
      check("R8 literal", rdata, 32'd0);
      ticks(1, 0);
      rd("R8 phase restart", 8'h58);

      // R5 repeat mode
      wr(8'h1C, 32'd3);
      wr(8'h00, 32'h01);
      wr(8'h10, 32'h13);
      ticks(10, 0);
      rd("R5 pend", 8'h04);
      rd("R5 count", 8'h18);
      check("R5 count literal", rdata, 32'd2);

      // R9 acknowledge
      wr(8'h10, 32'h10);
      wr(8'h08, 32'h3E);
      rd("R9 zero bits no effect", 8'h04);
      wr(8'h08, 32'h01);
      rd("R9 ack clears", 8'h04);
      wr(8'h1C, 32'd0);
      wr(8'h10, 32'h13);
      wr(8'h08, 32'h01, 1'b1);
      rd("R9 set wins", 8'h04);
      wr(8'h10, 32'h10);
      wr(8'h08, 32'h3F);

      // R6 one-shot
      wr(8'h6C, 32'd2);
      wr(8'h60, 32'h03);
      ticks(6, 0);
      rd("R6 count", 8'h68);
      check("R6 count literal", rdata, 32'd2);
      rd("R6 run dropped", 8'h60);
      rd("R6 pend", 8'h04);

      // R7 free-run wrap, modes 3 and 2
      wr(8'h30, 32'h31);
      wr(8'h38, 32'hFFFF_FFFE);
      wr(8'h3C, 32'h0);
      ticks(3, 0);
      rd("R7 wrap", 8'h38);
      check("R7 wrap literal", rdata, 32'd1);
      wr(8'h30, 32'h21);
      ticks(4, 0);
      rd("R7 reserved mode", 8'h38);
      rd("R7 no pend", 8'h04);

      // R10 raw pending vs enable mask
      wr(8'h00, 32'h00);
      rd("R10 raw pend", 8'h04);
      rd("R10 ien", 8'h00);
      wr(8'h00, 32'h20);
      ticks(2, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule